// File: doc/BRIEF.md
# SDRAM Bank Address Decoder

This block keeps one configuration word for each of several memory banks and turns a physical address into a bank decision. Each word packs an enable flag, a coarse base address and an encoded bank size. For every incoming address the block reports which banks match and whether any bank matches at all. It also reports the winning bank's index and the byte offset of the address inside that bank. The decode is combinational from the stored words, so a memory controller can use it in the same cycle it presents the address.

Software never addresses the bank words directly. It first writes a sub-address into a pointer register. Data-register reads and writes then go to the location the pointer names. Sub-addresses 0 up to the bank count minus one hold the bank words. A separate read-only sub-address returns a fixed memory-type word. Every other sub-address is empty.

Top module: `sdram_bank_decoder`

## Requirements
- R1: After reset every bank word reads 0, the pointer reads 0, and no address produces a hit.
- R2: A write with `cfg_sel`=0 loads the pointer from `cfg_wdata[7:0]`. A read with `cfg_sel`=0 returns the pointer zero-extended. Accesses with `cfg_sel`=1 act on the location the pointer currently holds.
- R3: Sub-addresses 0..3 hold bank words 0..3. A data write stores `cfg_wdata & 32'hFFE0FFC1`, so bits 20:16 and 5:1 always read back as 0.
- R4: Sub-address 0x20 reads 32'h2000_0000: bits 30:29 hold 1, which means the DDR1 memory type. Writes to this sub-address change nothing.
- R5: Every other sub-address reads 0, and a write to it leaves all bank words unchanged.
- R6: Bit 0 of a bank word enables the bank. A bank whose bit 0 is 0 never raises its `bank_hit` bit.
- R7: A bank's base is the 34-bit value formed by bits 31:21 of its word shifted left by 23.
- R8: With f = bits 15:6 of the word, the bank spans 2^(3 + 1024 − f) bytes, starting at the base rounded down to that size. If the exponent is 34 or more, the bank covers the whole 34-bit space.
- R9: `bank_hit[i]` shows the raw match of bank i, and `any_hit` is set exactly when some bank matches.
- R10: When several banks match, the lowest-numbered one wins. `bank_sel` carries its index and `bank_off` carries the address minus its (rounded) base. On a miss, both outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 1 | 0 = pointer register, 1 = data register |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational) |
| lkp_addr | input | 34 | Physical address to decode |
| bank_hit | output | 4 | Raw per-bank match |
| any_hit | output | 1 | Some bank matches |
| bank_sel | output | 2 | Index of the winning bank |
| bank_off | output | 34 | Offset inside the winning bank |

## Verification
The bench builds the block with its defaults: four banks, an 8-bit pointer and a 34-bit address. With 34 address bits, stepping through every 512 KiB granule with a varying low part takes 32768 vectors per configuration. That makes an exhaustive sweep of the whole space affordable. Three bank layouts are swept against an arithmetic reference:
- nested overlapping banks,
- a bank at the very top of the space,
- a bank whose size encoding of 0 covers everything.

Together they cover priority, edge-of-space bases and the oversize rule.

// File: rtl/sdb_pkg.sv
package sdb_pkg;
  localparam int CFG_W     = 32;
  localparam int BASE_LSB  = 23;
  localparam int BASE_BITS = 11;
  localparam int ADDR_W    = BASE_LSB + BASE_BITS;
  localparam int SIZE_LO   = 6;
  localparam int SIZE_BITS = 10;
  localparam int SIZE_SPAN = 1 << SIZE_BITS;
  localparam logic [CFG_W-1:0] WORD_KEEP = 32'hFFE0_FFC1;
  localparam logic [CFG_W-1:0] MODE_WORD = 32'h2000_0000;
endpackage

// File: rtl/sdb_rst_sync.sv
module sdb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/sdb_regs.sv
module sdb_regs #(
  parameter int NBANK = 4,
  parameter int SUB_W = 8,
  parameter logic [SUB_W-1:0] MODE_SUB = 8'h20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_we,
  input  logic cfg_sel,
  input  logic [sdb_pkg::CFG_W-1:0] cfg_wdata,
  output logic [sdb_pkg::CFG_W-1:0] cfg_rdata,
  output logic [SUB_W-1:0] sub_addr,
  output logic [NBANK-1:0][sdb_pkg::CFG_W-1:0] words
);
  import sdb_pkg::*;

  logic [SUB_W-1:0] sub_q, sub_d;
  logic [NBANK-1:0][CFG_W-1:0] words_q, words_d;
  logic upd_en;

  assign upd_en = cfg_we;

  always_comb begin
    sub_d   = sub_q;
    words_d = words_q;
    if (!cfg_sel) begin
      sub_d = cfg_wdata[SUB_W-1:0];
    end else begin
      for (int i = 0; i < NBANK; i++) begin
        if (sub_q == SUB_W'(i)) words_d[i] = cfg_wdata & WORD_KEEP;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sub_q   <= '0;
      words_q <= '0;
    end else if (upd_en) begin
      sub_q   <= sub_d;
      words_q <= words_d;
    end
  end

  always_comb begin
    cfg_rdata = '0;
    if (!cfg_sel) begin
      cfg_rdata = CFG_W'(sub_q);
    end else begin
      if (sub_q == MODE_SUB) cfg_rdata = MODE_WORD;
      for (int i = 0; i < NBANK; i++) begin
        if (sub_q == SUB_W'(i)) cfg_rdata = words_q[i];
      end
    end
  end

  assign sub_addr = sub_q;
  assign words    = words_q;
endmodule

// File: rtl/sdb_bank_match.sv
module sdb_bank_match #(
  parameter int UNIT_LG = 3
) (
  input  logic [sdb_pkg::CFG_W-1:0]  word,
  input  logic [sdb_pkg::ADDR_W-1:0] addr,
  output logic                       hit,
  output logic [sdb_pkg::ADDR_W-1:0] off
);
  import sdb_pkg::*;

  localparam int SH_W = SIZE_BITS + 2;

  logic [ADDR_W-1:0] base, mask;
  logic [SH_W-1:0]   shift_amt, lg;

  always_comb begin
    base      = {word[CFG_W-1 -: BASE_BITS], {BASE_LSB{1'b0}}};
    shift_amt = SH_W'(SIZE_SPAN) - SH_W'(word[SIZE_LO +: SIZE_BITS]);
    lg        = shift_amt + SH_W'(UNIT_LG);
    mask      = ~({ADDR_W{1'b1}} << lg);
    hit       = word[0] && ((addr & ~mask) == (base & ~mask));
    off       = addr & mask;
  end
endmodule

// File: rtl/sdb_pick.sv
module sdb_pick #(
  parameter int NBANK = 4,
  localparam int SEL_W = (NBANK > 1) ? $clog2(NBANK) : 1
) (
  input  logic [NBANK-1:0]                      hits,
  input  logic [NBANK-1:0][sdb_pkg::ADDR_W-1:0] offs,
  output logic                                  any,
  output logic [SEL_W-1:0]                      sel,
  output logic [sdb_pkg::ADDR_W-1:0]            off
);
  always_comb begin
    any = 1'b0;
    sel = '0;
    off = '0;
    for (int i = NBANK - 1; i >= 0; i--) begin
      if (hits[i]) begin
        any = 1'b1;
        sel = SEL_W'(i);
        off = offs[i];
      end
    end
  end
endmodule

// File: rtl/sdram_bank_decoder.sv
module sdram_bank_decoder #(
  parameter int NBANK   = 4,
  parameter int SUB_W   = 8,
  parameter int UNIT_LG = 3,
  parameter logic [SUB_W-1:0] MODE_SUB = 8'h20,
  localparam int SEL_W = (NBANK > 1) ? $clog2(NBANK) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_we,
  input  logic                       cfg_sel,
  input  logic [sdb_pkg::CFG_W-1:0]  cfg_wdata,
  output logic [sdb_pkg::CFG_W-1:0]  cfg_rdata,
  input  logic [sdb_pkg::ADDR_W-1:0] lkp_addr,
  output logic [NBANK-1:0]           bank_hit,
  output logic                       any_hit,
  output logic [SEL_W-1:0]           bank_sel,
  output logic [sdb_pkg::ADDR_W-1:0] bank_off
);
  import sdb_pkg::*;

  logic rst_n_sync;
  logic [SUB_W-1:0] sub_addr;
  logic [NBANK-1:0][CFG_W-1:0] words;
  logic [NBANK-1:0][ADDR_W-1:0] offs;

  sdb_rst_sync u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_sync)
  );

  sdb_regs #(.NBANK(NBANK), .SUB_W(SUB_W), .MODE_SUB(MODE_SUB)) u_regs (
    .clk(clk), .rst_n(rst_n_sync), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .sub_addr(sub_addr), .words(words)
  );

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    sdb_bank_match #(.UNIT_LG(UNIT_LG)) u_match (
      .word(words[g]), .addr(lkp_addr), .hit(bank_hit[g]), .off(offs[g])
    );
  end

  sdb_pick #(.NBANK(NBANK)) u_pick (
    .hits(bank_hit), .offs(offs), .any(any_hit), .sel(bank_sel), .off(bank_off)
  );
endmodule

// File: rtl/sdb_checker.sv
module sdb_checker #(
  parameter int NBANK = 4,
  parameter int SUB_W = 8,
  parameter int SEL_W = 2
) (
  input logic clk,
  input logic rst_n_sync,
  input logic cfg_we,
  input logic cfg_sel,
  input logic [sdb_pkg::CFG_W-1:0] cfg_wdata,
  input logic [SUB_W-1:0] sub_addr,
  input logic [NBANK-1:0][sdb_pkg::CFG_W-1:0] words,
  input logic [NBANK-1:0] bank_hit,
  input logic any_hit,
  input logic [SEL_W-1:0] bank_sel,
  input logic [sdb_pkg::ADDR_W-1:0] bank_off
);
  import sdb_pkg::*;

  // R2
  ptr_load_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (cfg_we && !cfg_sel) |=> (sub_addr == $past(cfg_wdata[SUB_W-1:0])));

  // R9
  winner_hits_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    any_hit |-> bank_hit[bank_sel]);

  // R10
  lowest_wins_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    any_hit |-> ((bank_hit & ((NBANK'(1) << bank_sel) - NBANK'(1))) == '0));

  // R10
  miss_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (bank_hit == '0) |-> (!any_hit && bank_sel == '0 && bank_off == '0));

  for (genvar g = 0; g < NBANK; g++) begin : g_chk
    // R6
    disabled_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
      !words[g][0] |-> !bank_hit[g]);
    // R3
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
      (words[g] & ~WORD_KEEP) == '0);
  end
endmodule

bind sdram_bank_decoder sdb_checker #(.NBANK(NBANK), .SUB_W(SUB_W), .SEL_W(SEL_W)) i_sdb_chk (
  .clk(clk), .rst_n_sync(rst_n_sync), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
  .cfg_wdata(cfg_wdata), .sub_addr(sub_addr), .words(words),
  .bank_hit(bank_hit), .any_hit(any_hit), .bank_sel(bank_sel), .bank_off(bank_off)
);

// File: tb/test_sdram_bank_decoder.sv
module test_sdram_bank_decoder;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic        cfg_sel;
  logic [31:0] cfg_wdata;
  logic [31:0] cfg_rdata;
  logic [33:0] lkp_addr;
  logic [3:0]  bank_hit;
  logic        any_hit;
  logic [1:0]  bank_sel;
  logic [33:0] bank_off;

  int vec = 0;
  int bad = 0;
  bit done = 1'b0;
  logic [31:0] model [4];

  always #5 clk = ~clk;

  sdram_bank_decoder i_sdram_bank_decoder (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .lkp_addr(lkp_addr),
    .bank_hit(bank_hit), .any_hit(any_hit), .bank_sel(bank_sel), .bank_off(bank_off)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    vec++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(posedge clk);
    #1 cfg_we = 1'b0;
  endtask

  task automatic reg_rd(input logic sel, output logic [31:0] d);
    @(negedge clk);
    cfg_sel = sel;
    #1 d = cfg_rdata;
  endtask

  task automatic bank_wr(input int b, input logic [31:0] d);
    reg_wr(1'b0, 32'(b));
    reg_wr(1'b1, d);
    model[b] = d & 32'hFFE0FFC1;
  endtask

  function automatic logic [31:0] mk(input int base, input int f, input bit en);
    return {base[10:0], 5'b0, f[9:0], 5'b0, en};
  endfunction

  task automatic ref_dec(input logic [33:0] a, output logic [3:0] hv, output logic anyh,
                         output logic [1:0] s, output logic [33:0] o);
    hv = '0; anyh = 1'b0; s = '0; o = '0;
    for (int b = 3; b >= 0; b--) begin
      longint unsigned base = longint'(model[b][31:21]) * 64'd8388608;
      int lg = 3 + 1024 - int'(model[b][15:6]);
      bit m;
      longint unsigned oo;
      if (lg >= 34) begin
        m = 1'b1; oo = longint'(a);
      end else begin
        longint unsigned sz = 64'd1 << lg;
        m  = (longint'(a) / sz) == (base / sz);
        oo = longint'(a) % sz;
      end
      m = m && model[b][0];
      hv[b] = m;
      if (m) begin anyh = 1'b1; s = 2'(b); o = 34'(oo); end
    end
  endtask

  task automatic sweep(input string tag);
    logic [3:0] ehv; logic eany; logic [1:0] es; logic [33:0] eo;
    for (int i = 0; i < 32768; i++) begin
      logic [33:0] a = (34'(i) << 19) | (34'(i * 40503) & 34'h7FFFF);
      lkp_addr = a;
      #1;
      ref_dec(a, ehv, eany, es, eo);
      check({bank_hit, any_hit, bank_sel, bank_off} == {ehv, eany, es, eo}, tag,
            64'({bank_hit, any_hit, bank_sel, bank_off}), 64'({ehv, eany, es, eo}));
    end
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      vec++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    for (int b = 0; b < 4; b++) model[b] = '0;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = 1'b0; cfg_wdata = '0; lkp_addr = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1: reset state
    reg_rd(1'b0, rd); check(rd == 32'h0, "R1 pointer", 64'(rd), 64'h0);
    for (int b = 0; b < 4; b++) begin
      reg_wr(1'b0, 32'(b)); reg_rd(1'b1, rd);
      check(rd == 32'h0, "R1 bank word", 64'(rd), 64'h0);
    end
    lkp_addr = 34'h0_0000_0000; #1;
    check({bank_hit, any_hit} == 5'b0, "R1 no hit", 64'({bank_hit, any_hit}), 64'h0);

    // R2: pointer loads low 8 bits
    reg_wr(1'b0, 32'hABCD_1234); reg_rd(1'b0, rd);
    check(rd == 32'h34, "R2 pointer truncation", 64'(rd), 64'h34);

    // R3: write mask on a bank word
    bank_wr(2, 32'hFFFF_FFFF);
    reg_wr(1'b0, 32'h2); reg_rd(1'b1, rd);
    check(rd == 32'hFFE0_FFC1, "R3 masked store", 64'(rd), 64'hFFE0FFC1);
    bank_wr(1, 32'h1234_5678);
    reg_rd(1'b1, rd);
    check(rd == (32'h1234_5678 & 32'hFFE0FFC1), "R3 masked store b1", 64'(rd), 64'(32'h1234_5678 & 32'hFFE0FFC1));

    // R4: memory-type word, read only
    reg_wr(1'b0, 32'h20); reg_rd(1'b1, rd);
    check(rd == 32'h2000_0000, "R4 mode word", 64'(rd), 64'h20000000);
    reg_wr(1'b1, 32'h0000_0000); reg_rd(1'b1, rd);
    check(rd == 32'h2000_0000, "R4 write ignored", 64'(rd), 64'h20000000);

    // R5: empty sub-addresses
    for (int s = 4; s < 8; s++) begin
      reg_wr(1'b0, 32'(s)); reg_wr(1'b1, 32'hFFFF_FFFF); reg_rd(1'b1, rd);
      check(rd == 32'h0, "R5 empty reads zero", 64'(rd), 64'h0);
    end
    for (int b = 0; b < 4; b++) begin
      reg_wr(1'b0, 32'(b)); reg_rd(1'b1, rd);
      check(rd == model[b], "R5 banks untouched", 64'(rd), 64'(model[b]));
    end

    // R6 R7 R8 R9 R10: nested overlap, one disabled bank covering all
    bank_wr(0, mk(1, 1004, 1'b1));
    bank_wr(1, mk(4, 1003, 1'b1));
    bank_wr(2, mk(5, 1006, 1'b1));
    bank_wr(3, mk(0, 0, 1'b0));
    sweep("R6/R7/R8/R9/R10 layout A");

    // R7 R8 R10: top-of-space bank plus a whole-space bank
    bank_wr(0, mk(11'h7FF, 1004, 1'b1));
    bank_wr(3, mk(0, 0, 1'b1));
    sweep("R7/R8/R10 layout B");

    // R6: disabling every bank
    for (int b = 0; b < 4; b++) bank_wr(b, model[b] & 32'hFFFF_FFFE);
    sweep("R6 all disabled");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule